// File: doc/BRIEF.md
# Serial DAC Frame Receiver

This block takes write frames arriving on a three-wire serial link: an active-low frame-select line, a serial clock and a data line. It runs entirely on a fast system clock. The three serial pins are synchronized into that domain, and edges on them are detected there. Each frame carries an 18-bit converter code. That code sits inside 24 serial bits, with padding bits on either side of it.

The block places the code in a holding register only when the frame is complete. On that same cycle it raises a single-cycle update strobe. A frame that is cut short by frame-select rising leaves the holding register untouched. After reset the holding register contains a power-up code, and a parameter selects whether that code is zero or midscale. A downstream converter or modulator reads the holding register directly.

The system clock must run at least four times faster than the serial clock. The data line must be stable around each falling edge of the serial clock.

Top module: `serial_dac_rx`

## Requirements
- R1: A frame begins only on a high-to-low transition of frame_sel_n. Serial clock edges seen while frame_sel_n is high, or before that transition, have no effect on code_o or update_o. A clock fall that is seen in the same system cycle as the select fall is not counted.
- R2: While a frame is open, ser_data is sampled on each falling edge of ser_clk. The first bit sampled is the most significant bit of the 24-bit frame.
- R3: Frame bits 19 down to 2 form the code, with bit 23 being the first bit sent. The four leading bits (23..20) and the two trailing bits (1..0) are ignored.
- R4: On the 24th falling edge of a frame, the code is loaded into code_o and update_o is high for exactly one system cycle.
- R5: If frame_sel_n goes high before the 24th falling edge, the frame is discarded. code_o keeps its value, no strobe occurs, and the next frame starts counting from bit 23 again.
- R6: After a completed frame, further falling edges are ignored while frame_sel_n stays low. A new frame needs frame_sel_n to rise and then fall.
- R7: After reset, code_o holds 0x00000 when RESET_MIDSCALE is 0 and 0x20000 when it is 1. This value is kept until the first complete frame.
- R8: Sometimes frame_sel_n rising and the 24th falling edge of ser_clk are seen in the same system cycle. In that case the abort wins: no load and no strobe.
- R9: code_o changes only in a cycle where update_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sel_n | input | 1 | Active-low frame select, asynchronous to clk |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edge |
| ser_data | input | 1 | Serial data, MSB first |
| code_o | output | 18 | Holding register contents |
| update_o | output | 1 | One-cycle pulse when code_o is loaded |

## Verification
Two events can land in the same system cycle: frame-select rising, and the 24th falling edge of the serial clock. The bench provokes this by driving both pins in the same system cycle after 23 completed bits. Both pins pass through synchronizers of equal depth, so the two edges arrive at the frame logic together. The result is judged at the ports: the strobe counter must not move and code_o must keep the previous value. A matching case is also covered, where the select fall and a clock fall coincide at the start of a frame.

// File: rtl/dacrx_pkg.sv
package dacrx_pkg;

    localparam int FRAME_BITS = 24;
    localparam int CODE_W     = 18;
    localparam int TRAIL_BITS = 2;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    typedef logic [CODE_W-1:0]     code_t;
    typedef logic [FRAME_BITS-1:0] frame_t;
    typedef logic [CNT_W-1:0]      bitcnt_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_DONE
    } rx_state_e;

    typedef struct packed {
        logic sclk_fall;
        logic sel_fall;
        logic sel_high;
        logic data;
    } pin_evt_t;

    function automatic code_t frame_code(input frame_t f);
        return f[TRAIL_BITS +: CODE_W];
    endfunction

    function automatic code_t powerup_code(input bit mid);
        return mid ? (code_t'(1) << (CODE_W - 1)) : '0;
    endfunction

endpackage

// File: rtl/dacrx_sync.sv
module dacrx_sync #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/dacrx_edge.sv
module dacrx_edge
    import dacrx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sel_s,
    input  logic     sclk_s,
    input  logic     data_s,
    output pin_evt_t evt_o
);

    logic sel_d;
    logic sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_d  <= 1'b1;
            sclk_d <= 1'b1;
        end else begin
            sel_d  <= sel_s;
            sclk_d <= sclk_s;
        end
    end

    always_comb begin
        evt_o.sclk_fall = sclk_d & ~sclk_s;
        evt_o.sel_fall  = sel_d & ~sel_s;
        evt_o.sel_high  = sel_s;
        evt_o.data      = data_s;
    end

endmodule

// File: rtl/dacrx_shifter.sv
module dacrx_shifter
    import dacrx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_evt_t evt_i,
    output logic     done_o,
    output code_t    code_o
);

    localparam bitcnt_t LAST_BIT = bitcnt_t'(FRAME_BITS - 1);

    rx_state_e              state;
    bitcnt_t                cnt;
    logic [FRAME_BITS-2:0]  sr;
    frame_t                 nxt;
    logic                   done_q;
    code_t                  code_q;

    assign nxt = {sr, evt_i.data};

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RX_IDLE;
            cnt    <= '0;
            sr     <= '0;
            done_q <= 1'b0;
            code_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    cnt <= '0;
                    sr  <= '0;
                    if (evt_i.sel_fall) state <= RX_SHIFT;
                end
                RX_SHIFT: begin
                    if (evt_i.sel_high) begin
                        state <= RX_IDLE;
                        cnt   <= '0;
                        sr    <= '0;
                    end else if (evt_i.sclk_fall) begin
                        sr <= nxt[FRAME_BITS-2:0];
                        if (cnt == LAST_BIT) begin
                            done_q <= 1'b1;
                            code_q <= frame_code(nxt);
                            cnt    <= '0;
                            state  <= RX_DONE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                RX_DONE: begin
                    if (evt_i.sel_high) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign done_o = done_q;
    assign code_o = code_q;

    // R5
    abort_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RX_SHIFT && evt_i.sel_high) |=> (state == RX_IDLE && cnt == '0 && !done_q));

    // R6
    done_ignores_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RX_DONE && !evt_i.sel_high) |=> (state == RX_DONE && !done_q));

    // R4
    done_source_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RX_SHIFT && !evt_i.sel_high && evt_i.sclk_fall && cnt == LAST_BIT) |=> done_q);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RX_IDLE) |=> !done_q);

endmodule

// File: rtl/dacrx_hold.sv
module dacrx_hold
    import dacrx_pkg::*;
#(
    parameter bit RESET_MIDSCALE = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load_i,
    input  code_t code_i,
    output code_t code_o,
    output logic  strobe_o
);

    localparam code_t RST_CODE = powerup_code(RESET_MIDSCALE);

    code_t code_q;
    logic  strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q   <= RST_CODE;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= load_i;
            if (load_i) code_q <= code_i;
        end
    end

    assign code_o   = code_q;
    assign strobe_o = strobe_q;

    // R4
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_q |=> !strobe_q);

    // R9
    code_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(code_q) |-> strobe_q);

endmodule

// File: rtl/serial_dac_rx.sv
module serial_dac_rx
    import dacrx_pkg::*;
#(
    parameter bit RESET_MIDSCALE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_sel_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    output logic [CODE_W-1:0] code_o,
    output logic              update_o
);

    logic [2:0] pins_s;
    pin_evt_t   evt;
    logic       frame_done;
    code_t      frame_val;
    code_t      hold_val;

    dacrx_sync #(
        .W       (3),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({frame_sel_n, ser_clk, ser_data}),
        .sync_o  (pins_s)
    );

    dacrx_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sel_s  (pins_s[2]),
        .sclk_s (pins_s[1]),
        .data_s (pins_s[0]),
        .evt_o  (evt)
    );

    dacrx_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .done_o (frame_done),
        .code_o (frame_val)
    );

    dacrx_hold #(
        .RESET_MIDSCALE (RESET_MIDSCALE)
    ) u_hold (
        .clk      (clk),
        .rst      (rst),
        .load_i   (frame_done),
        .code_i   (frame_val),
        .code_o   (hold_val),
        .strobe_o (update_o)
    );

    assign code_o = hold_val;

endmodule

// File: tb/test_serial_dac_rx.sv
module test_serial_dac_rx;

    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdi = 1'b0;
    logic [17:0] code_mid;
    logic [17:0] code_zero;
    logic        upd_mid;
    logic        upd_zero;

    int n_total = 0;
    int n_fail  = 0;
    int n_upd   = 0;
    logic [17:0] last_code;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    serial_dac_rx #(.RESET_MIDSCALE(1'b1)) i_serial_dac_rx (
        .clk (clk), .rst (rst), .frame_sel_n (sel_n), .ser_clk (sclk),
        .ser_data (sdi), .code_o (code_mid), .update_o (upd_mid)
    );

    serial_dac_rx #(.RESET_MIDSCALE(1'b0)) i_serial_dac_rx_zero (
        .clk (clk), .rst (rst), .frame_sel_n (sel_n), .ser_clk (sclk),
        .ser_data (sdi), .code_o (code_zero), .update_o (upd_zero)
    );

    always @(posedge clk) if (!rst && upd_mid) n_upd <= n_upd + 1;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_code(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s code actual=%05h expected=%05h", req, act, exp);
        end
    endtask

    task automatic chk_cnt(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s strobes actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Opens a frame, sends nfall bits of w from bit 23, optionally raises select.
    task automatic send(input logic [23:0] w, input int nfall, input bit close);
        sel_n = 1'b0;
        wait_clk(2 * HALF);
        for (int i = 0; i < nfall; i++) begin
            sdi = w[23 - i];
            wait_clk(HALF);
            sclk = 1'b0;
            wait_clk(HALF);
            sclk = 1'b1;
        end
        wait_clk(HALF);
        if (close) begin
            sel_n = 1'b1;
            wait_clk(3 * HALF);
        end
    endtask

    function automatic logic [23:0] mkframe(input logic [17:0] c, input int salt);
        logic [5:0] pad = 6'(salt * 37 + 11);
        return {pad[5:2], c, pad[1:0]};
    endfunction

    initial begin
        int exp_upd;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);

        // R7
        chk_code("R7 midscale", code_mid, 18'h20000);
        chk_code("R7 zero", code_zero, 18'h00000);
        chk_cnt("R7 no strobe", n_upd, 0);

        // R1: clocking with select high
        for (int i = 0; i < 30; i++) begin
            sdi = i[0];
            wait_clk(HALF); sclk = 1'b0; wait_clk(HALF); sclk = 1'b1;
        end
        wait_clk(8);
        chk_code("R1 idle clocks", code_mid, 18'h20000);
        chk_cnt("R1 idle clocks", n_upd, 0);

        // R2 R3 R4: walking ones plus patterns with varied padding
        exp_upd = 0;
        for (int b = 0; b < 18; b++) begin
            logic [17:0] c = 18'(1) << b;
            send(mkframe(c, b), 24, 1'b1);
            exp_upd++;
            chk_code("R2 R3 walking one", code_mid, c);
        end
        for (int p = 0; p < 6; p++) begin
            logic [17:0] c = 18'((p * 41_257 + 9_001) % 262_144);
            if (p == 0) c = 18'h3FFFF;
            if (p == 1) c = 18'h00000;
            send(mkframe(c, p + 100), 24, 1'b1);
            exp_upd++;
            chk_code("R3 pattern", code_mid, c);
            chk_code("R3 pattern zero-inst", code_zero, c);
        end
        chk_cnt("R4 one strobe per frame", n_upd, exp_upd);
        last_code = code_mid;

        // R5: aborted frames of several lengths, then a clean frame
        for (int k = 0; k < 4; k++) begin
            int len = (k == 0) ? 1 : (k == 1) ? 12 : (k == 2) ? 20 : 23;
            send(mkframe(18'h15A5A, k), len, 1'b1);
            chk_code("R5 abort keeps code", code_mid, last_code);
        end
        chk_cnt("R5 abort no strobe", n_upd, exp_upd);
        send(mkframe(18'h0C3C3, 7), 24, 1'b1);
        exp_upd++;
        chk_code("R5 fresh frame after abort", code_mid, 18'h0C3C3);
        last_code = code_mid;

        // R6: select held low after completion, extra clocks ignored
        send(mkframe(18'h2F0F0, 9), 24, 1'b0);
        exp_upd++;
        chk_code("R6 completed", code_mid, 18'h2F0F0);
        for (int i = 0; i < 24; i++) begin
            sdi = ~i[1];
            wait_clk(HALF); sclk = 1'b0; wait_clk(HALF); sclk = 1'b1;
        end
        wait_clk(8);
        chk_code("R6 extra clocks ignored", code_mid, 18'h2F0F0);
        chk_cnt("R6 no extra strobe", n_upd, exp_upd);
        sel_n = 1'b1;
        wait_clk(3 * HALF);
        send(mkframe(18'h01234, 3), 24, 1'b1);
        exp_upd++;
        chk_code("R6 reopen", code_mid, 18'h01234);
        last_code = code_mid;

        // R8: select rise together with the 24th fall
        send(mkframe(18'h3AAAA, 5), 23, 1'b0);
        sdi = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
        sel_n = 1'b1;
        wait_clk(HALF);
        sclk = 1'b1;
        wait_clk(10);
        chk_code("R8 collision abort", code_mid, last_code);
        chk_cnt("R8 collision no strobe", n_upd, exp_upd);

        // R1: select fall coinciding with a clock fall, that fall not counted
        begin
            logic [23:0] w = mkframe(18'h1E1E1, 2);
            sdi = 1'b0;
            wait_clk(HALF);
            sclk = 1'b0;
            sel_n = 1'b0;
            wait_clk(HALF);
            sclk = 1'b1;
            for (int i = 0; i < 24; i++) begin
                sdi = w[23 - i];
                wait_clk(HALF); sclk = 1'b0; wait_clk(HALF); sclk = 1'b1;
            end
            wait_clk(HALF);
            sel_n = 1'b1;
            wait_clk(3 * HALF);
            exp_upd++;
            chk_code("R1 coincident start", code_mid, 18'h1E1E1);
        end

        // R9 with R4: strobe count matches every load
        chk_cnt("R9 total strobes", n_upd, exp_upd);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule